// File: doc/BRIEF.md
# Control-Bus Transfer Contract Monitor

This block sits passively on one APB segment and watches the select, enable, ready, address, direction and write-data lines. It drives nothing onto the bus. It checks that every access follows the one-word, two-phase pattern. A select-only cycle comes first, then an enable cycle that lasts until ready. Each kind of misbehaviour sets its own sticky flag, and only the active-low reset clears these flags.

The monitor also counts completed accesses over a fixed window of clock cycles. If more accesses complete inside one window than a parameter allows, it latches an alarm. A control bus normally sees only sparse register accesses, so a high completion rate indicates that bulk data is being moved over the wrong bus. The window length and the threshold are parameters.

Top module: `apb_xfer_monitor`

## Requirements
- R1: After reset all five error flags, `xfer_count` and `rate_alarm` read 0.
- R2: A rise of `mon_en` sets `err_phase` unless the previous cycle was a setup cycle. A setup cycle has `mon_sel`=1 and `mon_en`=0.
- R3: After an access cycle with `mon_rdy`=0, the next cycle must again have `mon_sel`=1 and `mon_en`=1. If it does not, `err_hold` is set.
- R4: A completion is a cycle with `mon_sel`, `mon_en` and `mon_rdy` all 1. Each completion adds exactly one to `xfer_count` at the following clock edge.
- R5: An access cycle (`mon_sel`=1, `mon_en`=1) in the cycle right after a completion sets `err_chain`. A fresh setup cycle after a completion is legal.
- R6: A completion sets `err_short` when the cycle before it was neither a setup cycle nor a waiting access cycle. This means every access takes at least 2 cycles.
- R7: `err_drift` is set if, in any access cycle that follows a setup or a wait, `mon_addr` or `mon_wr` differs from its value in the setup cycle. It is also set if `mon_wdata` differs in a write. A change of `mon_wdata` during a read has no effect.
- R8: Clock edges after reset are grouped into windows of WINDOW edges. At the last edge of each window, `xfer_count` returns to 0.
- R9: `rate_alarm` is set at the edge that brings the count in one window above THRESH. It then stays at 1 until reset.
- R10: Every error flag, once set, stays at 1 until reset, whatever the bus does afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_sel | input | 1 | Observed peripheral select |
| mon_en | input | 1 | Observed enable (access phase) |
| mon_rdy | input | 1 | Observed ready |
| mon_addr | input | AW | Observed address |
| mon_wr | input | 1 | Observed direction, 1 = write |
| mon_wdata | input | DW | Observed write data |
| err_phase | output | 1 | Sticky: enable rose without a setup cycle |
| err_hold | output | 1 | Sticky: access abandoned before ready |
| err_chain | output | 1 | Sticky: access continued straight after a completion |
| err_short | output | 1 | Sticky: completion under two cycles |
| err_drift | output | 1 | Sticky: address, direction or write data moved during an access |
| xfer_count | output | $clog2(WINDOW+1) | Completions in the current window |
| rate_alarm | output | 1 | Sticky: window count exceeded THRESH |

## Verification
The bench builds the monitor with WINDOW=16, THRESH=3, AW=8 and DW=8. With a 16-cycle window, the bench can fill a window with back-to-back accesses and push it past the threshold. It can also cross several window boundaries within a short run. The sweep covers both directions with zero to three wait states. Each protocol fault is then injected on its own after a reset, so the bench can confirm that only the intended flag responds and that the flag stays set.

// File: rtl/apb_xfer_monitor.sv
module apb_xfer_monitor #(
  parameter int AW     = 12,
  parameter int DW     = 32,
  parameter int WINDOW = 256,
  parameter int THRESH = 32
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         mon_sel,
  input  logic                         mon_en,
  input  logic                         mon_rdy,
  input  logic [AW-1:0]                mon_addr,
  input  logic                         mon_wr,
  input  logic [DW-1:0]                mon_wdata,
  output logic                         err_phase,
  output logic                         err_hold,
  output logic                         err_chain,
  output logic                         err_short,
  output logic                         err_drift,
  output logic [$clog2(WINDOW+1)-1:0]  xfer_count,
  output logic                         rate_alarm
);
  localparam int CW = $clog2(WINDOW+1);
  localparam int WW = (WINDOW > 1) ? $clog2(WINDOW) : 1;

  logic en_q, setup_q, wait_q, done_q;
  logic [AW-1:0] cap_addr;
  logic          cap_wr;
  logic [DW-1:0] cap_wdata;
  logic [WW-1:0] wpos;

  wire setup  = mon_sel & ~mon_en;
  wire access = mon_sel &  mon_en;
  wire done   = access &  mon_rdy;
  wire stall  = access & ~mon_rdy;
  wire wrap   = (wpos == WW'(WINDOW-1));

  wire bad_rise  = mon_en & ~en_q & ~setup_q;
  wire bad_hold  = wait_q & ~access;
  wire bad_chain = done_q & access;
  wire bad_short = done & ~(setup_q | wait_q);
  wire live      = access & (setup_q | wait_q);
  wire bad_drift = live & ((mon_addr != cap_addr) | (mon_wr != cap_wr) |
                           (cap_wr & (mon_wdata != cap_wdata)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q    <= 1'b0;
      setup_q <= 1'b0;
      wait_q  <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      en_q    <= mon_en;
      setup_q <= setup;
      wait_q  <= stall;
      done_q  <= done;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_addr  <= '0;
      cap_wr    <= 1'b0;
      cap_wdata <= '0;
    end else if (setup) begin
      cap_addr  <= mon_addr;
      cap_wr    <= mon_wr;
      cap_wdata <= mon_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      err_phase <= 1'b0;
      err_hold  <= 1'b0;
      err_chain <= 1'b0;
      err_short <= 1'b0;
      err_drift <= 1'b0;
    end else begin
      err_phase <= err_phase | bad_rise;
      err_hold  <= err_hold  | bad_hold;
      err_chain <= err_chain | bad_chain;
      err_short <= err_short | bad_short;
      err_drift <= err_drift | bad_drift;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wpos       <= '0;
      xfer_count <= '0;
      rate_alarm <= 1'b0;
    end else begin
      wpos <= wrap ? '0 : wpos + 1'b1;
      if (wrap)      xfer_count <= '0;
      else if (done) xfer_count <= xfer_count + 1'b1;
      if (done && xfer_count == CW'(THRESH)) rate_alarm <= 1'b1;
    end
  end
endmodule

module apb_xfer_monitor_chk #(
  parameter int WINDOW = 256,
  parameter int THRESH = 32
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        mon_sel,
  input logic                        mon_en,
  input logic                        mon_rdy,
  input logic                        err_phase,
  input logic                        err_hold,
  input logic                        err_chain,
  input logic                        err_short,
  input logic                        err_drift,
  input logic [$clog2(WINDOW+1)-1:0] xfer_count,
  input logic                        rate_alarm
);
  // R2
  phase_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (mon_en && !$past(mon_en) && !($past(mon_sel) && !$past(mon_en))) |=> err_phase);
  // R3
  hold_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mon_sel && mon_en && !mon_rdy) && !(mon_sel && mon_en)) |=> err_hold);
  // R5
  chain_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mon_sel && mon_en && mon_rdy) && mon_sel && mon_en) |=> err_chain);
  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_count != 0) |-> ($past(xfer_count) + 1 == xfer_count && $past(mon_sel && mon_en && mon_rdy))
                          || $stable(xfer_count));
  // R9
  alarm_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(xfer_count) > THRESH) |-> rate_alarm);
  // R9
  alarm_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) !$fell(rate_alarm));
  // R10
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !($fell(err_phase) || $fell(err_hold) || $fell(err_chain) || $fell(err_short) || $fell(err_drift)));
  // R8
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(xfer_count) <= WINDOW);
endmodule

bind apb_xfer_monitor apb_xfer_monitor_chk #(.WINDOW(WINDOW), .THRESH(THRESH)) u_chk (
  .clk(clk), .rst_n(rst_n), .mon_sel(mon_sel), .mon_en(mon_en), .mon_rdy(mon_rdy),
  .err_phase(err_phase), .err_hold(err_hold), .err_chain(err_chain),
  .err_short(err_short), .err_drift(err_drift), .xfer_count(xfer_count),
  .rate_alarm(rate_alarm)
);

// File: tb/apb_xfer_monitor_bench.sv
module apb_xfer_monitor_bench;
  localparam int W = 16;
  localparam int T = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel = 0, en = 0, rdy = 0, wr = 0;
  logic [7:0] addr = 0, wdata = 0;
  logic e_phase, e_hold, e_chain, e_short, e_drift, alarm;
  logic [4:0] cnt;
  int total = 0, bad = 0, cycles = 0;
  int mcnt = 0, epos = 0;

  always #2 clk = ~clk;

  apb_xfer_monitor #(.AW(8), .DW(8), .WINDOW(W), .THRESH(T)) u_apb_xfer_monitor (
    .clk(clk), .rst_n(rst_n), .mon_sel(sel), .mon_en(en), .mon_rdy(rdy),
    .mon_addr(addr), .mon_wr(wr), .mon_wdata(wdata),
    .err_phase(e_phase), .err_hold(e_hold), .err_chain(e_chain),
    .err_short(e_short), .err_drift(e_drift), .xfer_count(cnt), .rate_alarm(alarm));

  // expected window count: completions since the start of the current window
  always @(posedge clk) begin
    cycles++;
    if (!rst_n) begin mcnt = 0; epos = 0; end
    else begin
      if (epos == W-1) mcnt = 0;
      else if (sel && en && rdy) mcnt++;
      epos = (epos == W-1) ? 0 : epos + 1;
    end
    if (cycles > 100000) begin
      bad++;
      $display("FAIL watchdog: actual=%0d cycles expected<100000", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 0; sel = 0; en = 0; rdy = 0; wr = 0; addr = 0; wdata = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  task automatic xfer(input logic w, input logic [7:0] a, input logic [7:0] d, input int waits);
    @(negedge clk); sel = 1; en = 0; rdy = 0; wr = w; addr = a; wdata = d;
    @(negedge clk); en = 1; rdy = (waits == 0);
    for (int i = 0; i < waits; i++) begin @(negedge clk); rdy = (i == waits-1); end
    @(negedge clk); sel = 0; en = 0; rdy = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    do_reset();
    // R1
    chk("R1 flags", {e_phase, e_hold, e_chain, e_short, e_drift}, 0);
    chk("R1 count", cnt, 0);
    chk("R1 alarm", alarm, 0);

    // sweep of legal accesses: R4 counting, quiet flags for R2 R3 R5 R6 R7
    for (int w = 0; w < 2; w++)
      for (int ws = 0; ws < 4; ws++) begin
        xfer(w[0], 8'(16*w+ws), 8'(3*ws+w), ws);
        chk("R4 count", cnt, mcnt);
        chk("R2 R3 R5 R6 R7 quiet", {e_phase, e_hold, e_chain, e_short, e_drift}, 0);
      end
    // R8: a full idle window leaves the count at zero
    idle(W);
    chk("R8 window clear", cnt, 0);

    // R5 R6: legal back-to-back with fresh setup
    do_reset();
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = 8'h11; wdata = 8'h22;
    @(negedge clk); en = 1; rdy = 1;
    @(negedge clk); en = 0; rdy = 0; addr = 8'h12;
    @(negedge clk); en = 1; rdy = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R5 legal b2b", e_chain, 0);
    chk("R6 legal b2b", e_short, 0);
    chk("R4 b2b count", cnt, 2);

    // R9: back-to-back fills the window past the threshold
    do_reset();
    for (int k = 0; k < 4; k++) xfer(1'b0, 8'(k), 8'h0, 0);
    chk("R9 alarm set", alarm, 1);
    idle(2*W);
    chk("R9 alarm latched", alarm, 1);
    chk("R8 count cleared", cnt, 0);

    // R9: sparse traffic keeps the alarm low
    do_reset();
    for (int k = 0; k < 6; k++) begin xfer(1'b1, 8'(k), 8'(k), 1); idle(W-4); end
    chk("R9 sparse no alarm", alarm, 0);

    // R2
    do_reset();
    @(negedge clk); sel = 1; en = 1; rdy = 0;
    @(negedge clk); sel = 0; en = 0;
    chk("R2 phase set", e_phase, 1);
    idle(5);
    chk("R10 phase sticky", e_phase, 1);

    // R3
    do_reset();
    @(negedge clk); sel = 1; en = 0;
    @(negedge clk); en = 1; rdy = 0;
    @(negedge clk); en = 0;
    @(negedge clk); sel = 0;
    chk("R3 hold set", e_hold, 1);
    chk("R3 no phase", e_phase, 0);

    // R5
    do_reset();
    @(negedge clk); sel = 1; en = 0;
    @(negedge clk); en = 1; rdy = 1;
    @(negedge clk);
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R5 chain set", e_chain, 1);
    chk("R4 chain count", cnt, 2);

    // R6
    do_reset();
    @(negedge clk); sel = 1; en = 1; rdy = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R6 short set", e_short, 1);
    idle(3);
    chk("R10 short sticky", e_short, 1);

    // R7: address moves during a wait
    do_reset();
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = 8'h40; wdata = 8'h5;
    @(negedge clk); en = 1; rdy = 0;
    @(negedge clk); addr = 8'h41; rdy = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R7 addr drift", e_drift, 1);

    // R7: write data moves
    do_reset();
    @(negedge clk); sel = 1; en = 0; wr = 1; addr = 8'h40; wdata = 8'h5;
    @(negedge clk); en = 1; rdy = 0;
    @(negedge clk); wdata = 8'h6; rdy = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R7 wdata drift", e_drift, 1);

    // R7: direction flips
    do_reset();
    @(negedge clk); sel = 1; en = 0; wr = 0; addr = 8'h40;
    @(negedge clk); en = 1; rdy = 1; wr = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R7 dir drift", e_drift, 1);

    // R7: write data moves during a read, ignored
    do_reset();
    @(negedge clk); sel = 1; en = 0; wr = 0; addr = 8'h40; wdata = 8'h1;
    @(negedge clk); en = 1; rdy = 0; wdata = 8'h9;
    @(negedge clk); wdata = 8'h3; rdy = 1;
    @(negedge clk); sel = 0; en = 0; rdy = 0;
    chk("R7 read wdata ignored", e_drift, 0);

    // R1 again after errors
    do_reset();
    chk("R1 reset clears", {e_phase, e_hold, e_chain, e_short, e_drift, alarm}, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule